// File: doc/BRIEF.md
# Audio Frame Skip/Repeat Controller

This controller sits between an audio frame decoder and the playback stage and applies lip-sync corrections that a host asks for. When audio lags the video, the host posts a one-shot skip request, and the next frame the decoder offers is thrown away. When audio leads the video, the host posts a one-shot repeat request, and the frame that just finished playing is played a second time. Each request clears itself once its action is done. Normal playback then resumes without any further host action.

The block works at frame granularity. The decoder offers whole frames on a valid/ready handshake. The playback stage signals the end of each frame with a strobe. For each frame slot the block issues one decision: play the new frame, drop it, or replay the buffered one. The slot opens at reset and again on the cycle after each end-of-frame strobe. Requests are evaluated only while a slot is open, so a request written in the middle of a frame applies at the next boundary. The block holds no frame data.

Top module: `frame_sync_ctrl`

## Requirements
- R1: After reset both request bits read 0, `in_ready` is 1, `act_stb` is 0, and neither done pulse is asserted.
- R2: A host write sets each request bit whose data bit is 1 (bit 0 = skip, bit 1 = repeat), visible on `host_rdata` from the next cycle. A data bit of 0 leaves that request unchanged.
- R3: With no request pending and a slot open, a frame offered on `in_valid` is accepted (`in_ready`=1) in the same cycle, with `act_stb`=1 and `act_code`=01 (play). `in_ready` then stays 0 until the cycle after the next `frm_end`.
- R4: With only skip pending and a slot open, the next accepted frame gets `act_code`=10 (drop) and `skip_done` pulses in that cycle. The skip bit reads 0 from the next cycle, and the slot stays open so the following frame is accepted and played.
- R5: With only repeat pending, a slot open and a frame played since reset, the block issues `act_code`=11 (replay) without accepting input, and the repeat bit reads 0 from the next cycle.
- R6: During a replay, `in_ready` stays 0 until the `frm_end` that ends the replay. `rep_done` pulses with that `frm_end`, and the next offered frame is played.
- R7: If skip and repeat are both pending at an open slot, the next offered frame is played (code 01), both bits clear, and no done pulse is given.
- R8: A request written while a frame is playing does not change the current decisions or handshake. It takes effect at the next open slot.
- R9: A repeat request pending before any frame has been played stays pending, and the first offered frame is played normally.
- R10: A host write that sets a bit in the same cycle its action completes leaves that bit pending, so the action is performed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the request register |
| host_wdata | input | 2 | Write data: bit 0 skip, bit 1 repeat; 1 sets, 0 ignored |
| host_rdata | output | 2 | Pending requests: bit 0 skip, bit 1 repeat |
| in_valid | input | 1 | Decoder offers a new frame |
| in_ready | output | 1 | Block accepts the offered frame |
| frm_end | input | 1 | Playback of the current frame has ended |
| act_stb | output | 1 | A decision is issued this cycle |
| act_code | output | 2 | Decision: 01 play, 10 drop, 11 replay, 00 none |
| skip_done | output | 1 | Pulse: a frame was dropped |
| rep_done | output | 1 | Pulse: a replay finished |

## Verification
The assertions assume that `frm_end` arrives only while a frame or a replay is playing, never while a slot is open, and that `in_valid` may be held for any number of cycles. The vector table and the directed tests raise `frm_end` only after a play or replay decision, so the stimulus stays within that assumption. The stimulus also offers frames during playback and replay to exercise backpressure. It writes requests both mid-frame and in the cycle an action completes.

// File: rtl/fsr_pkg.sv
// Package: shared decision codes and request indices for the frame
// skip/repeat controller. Assumes exactly two request kinds.
package fsr_pkg;
    localparam int NREQ    = 2;
    localparam int REQ_SKP = 0;
    localparam int REQ_RPT = 1;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_PLAY   = 2'b01,
        ACT_DROP   = 2'b10,
        ACT_REPLAY = 2'b11
    } act_e;
endpackage

// File: rtl/fsr_req_bank.sv
// Module: bank of write-one-to-set, self-clearing request bits.
// Assumes clr comes from the scheduler; a host set in the same cycle
// as a clear wins, so the request stays pending.
module fsr_req_bank #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Per-bit pending flag: set beats clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[i] <= 1'b0;
            else if (wr && wdata[i])
                pend[i] <= 1'b1;
            else if (clr[i])
                pend[i] <= 1'b0;
        end

        p_set_wins_r10 : assert property (@(posedge clk) disable iff (!rst_n)
            (wr && wdata[i]) |=> pend[i]);
    end
endmodule

// File: rtl/fsr_sched.sv
// Module: per-slot decision scheduler. A slot is open after reset and
// on the cycle after each frm_end. Assumes frm_end only arrives while a
// frame or replay is playing.
module fsr_sched
    import fsr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            skp,
    input  logic            rpt,
    input  logic            in_valid,
    input  logic            frm_end,
    output logic            in_ready,
    output logic            act_stb,
    output act_e            act_code,
    output logic [NREQ-1:0] clr,
    output logic            skip_done,
    output logic            rep_done
);
    logic open_q;
    logic have_q;
    logic replaying_q;
    logic rep_now;
    logic take;
    logic drop;
    logic both;

    // Slot decision terms, evaluated only while a slot is open.
    always_comb begin
        both      = skp && rpt;
        rep_now   = open_q && rpt && !skp && have_q;
        in_ready  = open_q && !rep_now;
        take      = in_ready && in_valid;
        drop      = take && skp && !rpt;
        act_stb   = rep_now || take;
        if (rep_now)
            act_code = ACT_REPLAY;
        else if (drop)
            act_code = ACT_DROP;
        else if (take)
            act_code = ACT_PLAY;
        else
            act_code = ACT_NONE;
        clr[REQ_SKP] = drop || (take && both);
        clr[REQ_RPT] = rep_now || (take && both);
        skip_done    = drop;
        rep_done     = frm_end && replaying_q;
    end

    // Slot state: open/playing, frame-seen flag, replay-in-progress flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q      <= 1'b1;
            have_q      <= 1'b0;
            replaying_q <= 1'b0;
        end else if (rep_now) begin
            open_q      <= 1'b0;
            replaying_q <= 1'b1;
        end else if (take && !drop) begin
            open_q <= 1'b0;
            have_q <= 1'b1;
        end else if (frm_end && !open_q) begin
            open_q      <= 1'b1;
            replaying_q <= 1'b0;
        end
    end

    p_end_while_playing_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        frm_end |-> !open_q);
    p_play_closes_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (act_stb && act_code == ACT_PLAY) |=> !in_ready);
    p_replay_holds_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (act_stb && act_code == ACT_REPLAY) |=> !in_ready);
    p_single_done_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({skip_done, rep_done}));
endmodule

// File: rtl/frame_sync_ctrl.sv
// Module: top of the audio frame skip/repeat controller. Joins the host
// request bank and the slot scheduler. Assumes the host write port and
// the frame handshakes are synchronous to clk.
module frame_sync_ctrl
    import fsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic [1:0] host_wdata,
    output logic [1:0] host_rdata,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       frm_end,
    output logic       act_stb,
    output logic [1:0] act_code,
    output logic       skip_done,
    output logic       rep_done
);
    logic [NREQ-1:0] pend;
    logic [NREQ-1:0] clr;
    act_e            code;

    fsr_req_bank #(.N(NREQ)) u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (host_wr),
        .wdata (host_wdata),
        .clr   (clr),
        .pend  (pend)
    );

    fsr_sched u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .skp       (pend[REQ_SKP]),
        .rpt       (pend[REQ_RPT]),
        .in_valid  (in_valid),
        .frm_end   (frm_end),
        .in_ready  (in_ready),
        .act_stb   (act_stb),
        .act_code  (code),
        .clr       (clr),
        .skip_done (skip_done),
        .rep_done  (rep_done)
    );

    // Expose pending state and decision code.
    always_comb begin
        host_rdata = pend;
        act_code   = code;
    end

    p_skip_clears_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (skip_done && !(host_wr && host_wdata[REQ_SKP])) |=> !host_rdata[REQ_SKP]);
    p_repeat_clears_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (act_stb && act_code == 2'b11 && !(host_wr && host_wdata[REQ_RPT]))
            |=> !host_rdata[REQ_RPT]);
endmodule

// File: tb/tb_frame_sync_ctrl.sv
module tb_frame_sync_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [1:0] host_wdata = 2'b00;
    logic [1:0] host_rdata;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       frm_end = 1'b0;
    logic       act_stb;
    logic [1:0] act_code;
    logic       skip_done;
    logic       rep_done;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    frame_sync_ctrl dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .in_valid(in_valid), .in_ready(in_ready),
        .frm_end(frm_end), .act_stb(act_stb), .act_code(act_code),
        .skip_done(skip_done), .rep_done(rep_done)
    );

    // Inputs {wr, wd1, wd0, in_valid, frm_end}; expected
    // {in_ready, act_stb, code1, code0, skip_done, rep_done, rdata1, rdata0}
    // sampled at the falling edge of the same cycle.
    localparam int NV = 27;
    localparam logic [12:0] VEC [NV] = '{
        {5'b00000, 8'b10000000},  // 0  idle
        {5'b00010, 8'b11010000},  // 1  play
        {5'b00000, 8'b00000000},  // 2
        {5'b10100, 8'b00000000},  // 3  skip written mid-frame
        {5'b00010, 8'b00000001},  // 4  offer while playing
        {5'b00001, 8'b00000001},  // 5  end
        {5'b00010, 8'b11101001},  // 6  drop
        {5'b00010, 8'b11010000},  // 7  next played
        {5'b11000, 8'b00000000},  // 8  repeat written
        {5'b10000, 8'b00000010},  // 9  write zeros
        {5'b00011, 8'b00000010},  // 10 end
        {5'b00010, 8'b01110010},  // 11 replay
        {5'b00010, 8'b00000000},  // 12 held off
        {5'b00011, 8'b00000100},  // 13 replay ends
        {5'b00010, 8'b11010000},  // 14 next played
        {5'b11100, 8'b00000000},  // 15 both written
        {5'b00001, 8'b00000011},  // 16 end
        {5'b00000, 8'b10000011},  // 17 waiting, no replay
        {5'b00010, 8'b11010011},  // 18 play, both clear
        {5'b00000, 8'b00000000},  // 19
        {5'b11001, 8'b00000000},  // 20 end + repeat write
        {5'b11000, 8'b01110010},  // 21 replay + rewrite
        {5'b00000, 8'b00000010},  // 22 still pending
        {5'b00001, 8'b00000110},  // 23 replay ends
        {5'b00000, 8'b01110010},  // 24 second replay
        {5'b00001, 8'b00000100},  // 25 ends
        {5'b00010, 8'b11010000}   // 26 play
    };

    function automatic string vtag(input int i);
        case (i)
            3, 4, 5:            return "R8";
            6:                  return "R4";
            7:                  return "R4";
            8, 9:               return "R2";
            10, 11:             return "R5";
            12, 13, 14:         return "R6";
            15, 16, 17, 18, 19: return "R7";
            20, 21, 22:         return "R10";
            23, 24, 25:         return "R10";
            default:            return "R3";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] outs();
        return {in_ready, act_stb, act_code, skip_done, rep_done, host_rdata};
    endfunction

    task automatic drive(input logic [4:0] v);
        host_wr    = v[4];
        host_wdata = v[3:2];
        in_valid   = v[1];
        frm_end    = v[0];
    endtask

    task automatic step(input logic [4:0] v);
        @(posedge clk); #1;
        drive(v);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        drive(5'b00000);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        check("R1 reset state", outs(), 8'b10000000);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][12:8]);
            check($sformatf("%s vector %0d", vtag(i), i), outs(), VEC[i][7:0]);
        end

        // R9: repeat pending before any frame has played.
        do_reset();
        step(5'b11000);
        check("R9 repeat write, no replay yet", outs(), 8'b10000000);
        step(5'b00000);
        check("R9 still waiting for first frame", outs(), 8'b10000010);
        step(5'b00010);
        check("R9 first frame played", outs(), 8'b11010010);
        step(5'b00001);
        check("R9 end of first frame", outs(), 8'b00000010);
        step(5'b00010);
        check("R5 replay after first frame", outs(), 8'b01110010);

        // R1: reset in the middle of a replay.
        do_reset();
        check("R1 reset mid-replay", outs(), 8'b10000000);
        step(5'b00010);
        check("R3 play after reset", outs(), 8'b11010000);

        // R4: skip posted while idle, with no frame offered yet.
        step(5'b00001);
        step(5'b10100);
        check("R4 skip pending, nothing offered", outs(), 8'b10000000);
        step(5'b00010);
        check("R4 drop on first offer", outs(), 8'b11101001);
        step(5'b00010);
        check("R4 following frame played", outs(), 8'b11010000);

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #20000;
        if (!done_flag) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule